// File: doc/BRIEF.md
# Fifteen-Cent Coin Vending Controller

This block is a synchronous Mealy controller for a vending machine that takes two coin values, five cents and ten cents, and releases one item once fifteen cents have been collected. Each clock cycle it sees at most one clean coin strobe. It keeps the credit collected so far (zero, five or ten cents) in a small state register.

The two outputs depend on the current credit and the coin strobe in the same cycle. When a coin completes a sale, the vend pulse is high for that one cycle. If a ten-cent coin lands on a ten-cent credit, the machine also pulses a change request worth one five-cent coin. Every sale returns the credit to zero.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the credit goes to zero. Both `vend_o` and `change_o` are low during that cycle and in the cycle that follows.
- R2: In a cycle with neither strobe high, the credit is held and both outputs are low.
- R3: In a cycle with both strobes high, the input is invalid. The credit is held and both outputs are low.
- R4: From zero credit, a five-cent strobe moves the credit to five and a ten-cent strobe moves it to ten. Neither raises an output.
- R5: From five credit, a five-cent strobe moves the credit to ten with no output. A ten-cent strobe raises `vend_o` alone and clears the credit.
- R6: From ten credit, a five-cent strobe raises `vend_o` alone and clears the credit.
- R7: From ten credit, a ten-cent strobe raises both `vend_o` and `change_o` and clears the credit.
- R8: `change_o` is never high without `vend_o`, and each output is high only in the cycle of the coin that completes the sale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | Five-cent coin strobe, one cycle per coin |
| dime_i | input | 1 | Ten-cent coin strobe, one cycle per coin |
| vend_o | output | 1 | Dispense pulse (Mealy) |
| change_o | output | 1 | Return-five-cents pulse (Mealy) |

## Verification
The in-line assertions check several rules on every cycle: change is never given without a vend, idle and invalid cycles leave the credit held and the outputs low, and a vend is followed by a cleared credit. The credit is internal. So only the bench's coin sequences can show that each path through the transition table adds up correctly, for example five then five then five, ten then ten, or an illegal double strobe placed in the middle of a purchase. The bench also shows that a reset in mid-purchase throws away the partial credit.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;
    localparam int CREDIT_W = 2;

    typedef enum logic [CREDIT_W-1:0] {
        CR_ZERO = 2'd0,
        CR_FIVE = 2'd1,
        CR_TEN  = 2'd2
    } credit_e;

    typedef enum logic [1:0] {
        COIN_NONE,
        COIN_NICKEL,
        COIN_DIME,
        COIN_BAD
    } coin_e;

    typedef struct packed {
        credit_e credit;
        logic    vend;
        logic    change;
    } step_t;
endpackage

// File: rtl/coin_decode.sv
module coin_decode
    import coin_vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);
    always_comb begin
        unique case ({dime_i, nickel_i})
            2'b01:   coin_o = COIN_NICKEL;
            2'b10:   coin_o = COIN_DIME;
            2'b11:   coin_o = COIN_BAD;
            default: coin_o = COIN_NONE;
        endcase
    end
endmodule

// File: rtl/credit_step.sv
module credit_step
    import coin_vend_pkg::*;
(
    input  credit_e credit_i,
    input  coin_e   coin_i,
    output step_t   step_o
);
    always_comb begin
        step_o.credit = credit_i;
        step_o.vend   = 1'b0;
        step_o.change = 1'b0;
        unique case (credit_i)
            CR_ZERO: begin
                if (coin_i == COIN_NICKEL) step_o.credit = CR_FIVE;
                if (coin_i == COIN_DIME)   step_o.credit = CR_TEN;
            end
            CR_FIVE: begin
                if (coin_i == COIN_NICKEL) step_o.credit = CR_TEN;
                if (coin_i == COIN_DIME) begin
                    step_o.credit = CR_ZERO;
                    step_o.vend   = 1'b1;
                end
            end
            CR_TEN: begin
                if (coin_i == COIN_NICKEL || coin_i == COIN_DIME) begin
                    step_o.credit = CR_ZERO;
                    step_o.vend   = 1'b1;
                    step_o.change = (coin_i == COIN_DIME);
                end
            end
            default: step_o.credit = CR_ZERO;
        endcase
    end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import coin_vend_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic nickel_i,
    input  logic dime_i,
    output logic vend_o,
    output logic change_o
);
    coin_e   coin;
    step_t   step;
    credit_e credit_q, credit_d;

    coin_decode u_dec (.nickel_i(nickel_i), .dime_i(dime_i), .coin_o(coin));
    credit_step u_step (.credit_i(credit_q), .coin_i(coin), .step_o(step));

    always_comb begin
        credit_d = rst_i ? CR_ZERO : step.credit;
        vend_o   = rst_i ? 1'b0 : step.vend;
        change_o = rst_i ? 1'b0 : step.change;
    end

    always_ff @(posedge clk_i) begin
        credit_q <= credit_d;
    end

    assert_change_needs_vend_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        change_o |-> vend_o);
    assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!nickel_i && !dime_i) |=> (credit_q == $past(credit_q)));
    assert_bad_coin_quiet_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (nickel_i && dime_i) |-> (!vend_o && !change_o));
    assert_vend_clears_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        vend_o |=> (credit_q == CR_ZERO));
    assert_change_only_ten_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        change_o |-> (credit_q == CR_TEN && dime_i));
    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        rst_i |-> (!vend_o && !change_o));
endmodule

// File: tb/coin_vend_ctrl_bench.sv
module coin_vend_ctrl_bench;
    logic clk = 1'b0;
    logic rst, nk, dm;
    logic vend, chg;
    int   n_cmp = 0, n_bad = 0;
    int   model_credit = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    coin_vend_ctrl u_coin_vend_ctrl (.clk_i(clk), .rst_i(rst), .nickel_i(nk), .dime_i(dm),
                                     .vend_o(vend), .change_o(chg));

    task automatic step(input bit r, input bit n, input bit d, input string req);
        int val, exp_v, exp_c, nxt;
        rst = r; nk = n; dm = d;
        #2;
        exp_v = 0; exp_c = 0; nxt = model_credit;
        if (r) nxt = 0;
        else if (n ^ d) begin
            val = model_credit + (n ? 5 : 10);
            if (val >= 15) begin
                exp_v = 1; exp_c = (val == 20); nxt = 0;
            end else nxt = val;
        end
        n_cmp++;
        if (vend !== exp_v[0] || chg !== exp_c[0]) begin
            n_bad++;
            $display("FAIL %s: vend/change = %b%b expected %b%b (credit %0d)",
                     req, vend, chg, exp_v[0], exp_c[0], model_credit);
        end
        @(posedge clk);
        model_credit = nxt;
        #2;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: expired, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; nk = 0; dm = 0;
        @(negedge clk);
        step(1, 0, 0, "R1"); step(1, 1, 1, "R1");
        step(0, 0, 0, "R1");
        step(0, 0, 0, "R2");
        // R4/R5/R6: nickel x3
        step(0, 1, 0, "R4"); step(0, 0, 0, "R2"); step(0, 1, 0, "R5"); step(0, 1, 0, "R6");
        // R4/R7: dime dime
        step(0, 0, 1, "R4"); step(0, 0, 1, "R7");
        // R5: nickel dime
        step(0, 1, 0, "R4"); step(0, 0, 1, "R5");
        // R3: invalid mid-purchase, then finish
        step(0, 1, 0, "R4"); step(0, 1, 1, "R3"); step(0, 1, 0, "R3");
        step(0, 1, 1, "R3"); step(0, 0, 1, "R7");
        // R8: single-cycle pulse; following idle quiet
        step(0, 0, 0, "R8");
        // R6: dime then nickel
        step(0, 0, 1, "R4"); step(0, 1, 0, "R6"); step(0, 0, 0, "R8");
        // R1: reset in mid-purchase drops credit
        step(0, 0, 1, "R4"); step(1, 0, 1, "R1"); step(0, 1, 0, "R1"); step(0, 1, 0, "R1");
        step(0, 1, 0, "R1");
        // pseudo-random run
        for (int i = 0; i < 400; i++) begin
            int r = (i * 37 + 11) % 7;
            step(i % 97 == 50, r == 1 || r == 4 || r == 6, r == 2 || r == 5 || r == 6, "R8");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule